// File: doc/BRIEF.md
# Ethernet MAC Statistics Counter Bank

This block sits next to an Ethernet MAC and turns per-frame status reports into a bank of event and byte counters. In any cycle the receive path and the transmit path may each present one report. A report gives the frame length (FCS bytes included) and a set of flags: the FCS result, the address class (broadcast or multicast), whether the frame is a pause or other control frame, and the error or drop causes. The block classifies each report and bumps every counter the report qualifies for. Counters include good frames, address classes, FCS and length errors, short frames split by FCS result, a seven-bin length histogram per direction, oversize and truncation, drop causes on receive, and collision and deferral outcomes on transmit.

Every counter saturates at its all-ones value and never wraps. A synchronous bank-clear input zeroes all of them. Software reads one counter at a time by index through a registered read port. An update flag is raised by hardware whenever a report changes the bank, and it stays raised until software clears it.

Top module: `macStatBank`

## Requirements
- R1: `rdData` shows the counter chosen by `rdIdx` one clock after `rdIdx` is sampled, and reads 0 for any index of 45 or above. Index map: 0 rx good, 1 rx broadcast, 2 rx multicast, 3 rx pause, 4 rx control, 5 rx FCS error, 6 rx length error, 7 rx runt, 8 rx fragment, 9..15 rx length bins 0..6, 16 rx oversize, 17 rx FIFO drop, 18 rx ring drop, 19 rx address drop, 20 rx bytes, 21 rx broadcast bytes, 22 rx multicast bytes, 23 tx good, 24 tx broadcast, 25 tx multicast, 26 tx pause, 27 tx control, 28 tx deferred, 29 tx excessively deferred, 30 tx one collision, 31 tx several collisions, 32 tx late collision, 33 tx collision abort, 34 tx truncated, 35..41 tx length bins 0..6, 42 tx bytes, 43 tx broadcast bytes, 44 tx multicast bytes.
- R2: A receive frame is good when its FCS is good, its length is between 64 and `mtu` inclusive, and no length-error or drop flag is set. A transmit frame is good when its length is between 64 and `mtu` and neither late collision nor abort is flagged. Good frames count in the good counter and, by flag, in the broadcast or multicast counter.
- R3: Byte counters add the frame length minus 4 for good frames only. The broadcast-byte and multicast-byte counters do the same for good frames of that class.
- R4: A receive frame under 64 bytes counts as a runt when its FCS is good and as a fragment when its FCS is bad. The FCS error counter counts bad-FCS frames of 64 bytes or more only.
- R5: Good frames fall in length bins: bin 0 is exactly 64, bin 1 is 65..127, bin 2 is 128..255, bin 3 is 256..511, bin 4 is 512..1023, bin 5 is 1024..1518, and bin 6 is 1519 up to `mtu`. Receive and transmit each have their own bins.
- R6: A receive frame longer than `mtu` counts in the oversize counter, and a transmit frame longer than `mtu` counts in the truncation counter. Neither counts as good.
- R7: The pause counters count good pause frames. The control counters count good control frames that are not pause frames.
- R8: A good transmit frame with exactly one collision counts in the one-collision counter, and one with two or more collisions counts in the several-collision counter. Late collision, abort, deferral and excessive deferral each have their own counter, which counts whenever the flag is set.
- R9: Receive FIFO overflow, descriptor-ring overflow, address-filter drop and length-error flags each increment their own counter.
- R10: Each counter saturates at all ones. Further events leave it at all ones.
- R11: Reset, or a cycle with `bankClr` high, leaves every counter at 0 and the update flag low.
- R12: `updFlag` rises in the cycle after any valid report and stays high until a `flagClr` cycle that has no report. If a report and `flagClr` arrive together, the flag ends up set.
- R13: Receive and transmit reports in the same cycle are both applied in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bankClr | input | 1 | Synchronous clear of all counters and the flag |
| mtu | input | 16 | Largest legal frame length, normally 1518 |
| rxValid | input | 1 | Receive report present |
| rxLen | input | 16 | Receive frame length, FCS included |
| rxFcsOk | input | 1 | Receive FCS good |
| rxBcast | input | 1 | Receive frame is broadcast |
| rxMcast | input | 1 | Receive frame is multicast |
| rxPause | input | 1 | Receive frame is pause |
| rxCtrl | input | 1 | Receive frame is a control frame |
| rxLenErr | input | 1 | Receive length field mismatch |
| rxFifoOvf | input | 1 | Receive frame dropped, FIFO overflow |
| rxRingOvf | input | 1 | Receive frame dropped, descriptor ring full |
| rxAddrDrop | input | 1 | Receive frame dropped by address filter |
| txValid | input | 1 | Transmit report present |
| txLen | input | 16 | Transmit frame length, FCS included |
| txBcast | input | 1 | Transmit frame is broadcast |
| txMcast | input | 1 | Transmit frame is multicast |
| txPause | input | 1 | Transmit frame is pause |
| txCtrl | input | 1 | Transmit frame is a control frame |
| txColls | input | 4 | Collisions before the frame went out |
| txLateCol | input | 1 | Late collision |
| txAbort | input | 1 | Aborted after excessive collisions |
| txDefer | input | 1 | Frame was deferred |
| txExcDefer | input | 1 | Frame was excessively deferred |
| rdIdx | input | 6 | Counter index to read |
| rdData | output | CNT_W | Counter value, one cycle after the index |
| flagClr | input | 1 | Software clear of the update flag |
| updFlag | output | 1 | Set by any report, cleared by software |

## Verification
A report sampled at one edge changes the counters at that edge, and `updFlag` shows the change right after it. The counter value reaches `rdData` only at the following edge, because the read port adds one register, so a count is visible two edges after its report. The bench drives on the falling edge, sets `rdIdx` after the report edge, and samples `rdData` on the falling edge after the next rising edge. It reads the flag on the falling edge right after the report. To reach saturation in a short run, the bench builds the bank with 12-bit counters.

// File: rtl/macStatPkg.sv
package macStatPkg;
  localparam int LEN_W   = 16;
  localparam int NUM_CNT = 45;
  localparam int IDX_W   = $clog2(NUM_CNT);
  localparam int BIN_CNT = 7;

  // receive counters
  localparam int RX_GOOD = 0,  RX_BCAST = 1,  RX_MCAST = 2,  RX_PAUSE = 3;
  localparam int RX_CTRL = 4,  RX_FCSERR = 5, RX_LENERR = 6, RX_RUNT = 7;
  localparam int RX_FRAG = 8,  RX_BIN0 = 9,   RX_OVERSIZE = 16;
  localparam int RX_FIFODROP = 17, RX_RINGDROP = 18, RX_ADDRDROP = 19;
  localparam int RX_BYTES = 20, RX_BCBYTES = 21, RX_MCBYTES = 22;
  // transmit counters
  localparam int TX_GOOD = 23, TX_BCAST = 24, TX_MCAST = 25, TX_PAUSE = 26;
  localparam int TX_CTRL = 27, TX_DEFER = 28, TX_EXCDEFER = 29;
  localparam int TX_ONECOL = 30, TX_MULTICOL = 31, TX_LATECOL = 32;
  localparam int TX_ABORT = 33, TX_TRUNC = 34, TX_BIN0 = 35;
  localparam int TX_BYTES = 42, TX_BCBYTES = 43, TX_MCBYTES = 44;

  localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(64);
  localparam logic [LEN_W-1:0] FCS_LEN = LEN_W'(4);

  typedef struct packed {
    logic [NUM_CNT-1:0] hit;
    logic [LEN_W-1:0]   rxBytes;
    logic [LEN_W-1:0]   txBytes;
    logic               update;
  } strobe_t;

  function automatic bit isRxByte(int idx);
    return idx == RX_BYTES || idx == RX_BCBYTES || idx == RX_MCBYTES;
  endfunction

  function automatic bit isTxByte(int idx);
    return idx == TX_BYTES || idx == TX_BCBYTES || idx == TX_MCBYTES;
  endfunction

  // Histogram bin of a length; BIN_CNT means no bin.
  function automatic logic [2:0] lenBin(logic [LEN_W-1:0] len, logic [LEN_W-1:0] mtu);
    if (len < MIN_LEN)             return 3'(BIN_CNT);
    else if (len == MIN_LEN)       return 3'd0;
    else if (len <= LEN_W'(127))   return 3'd1;
    else if (len <= LEN_W'(255))   return 3'd2;
    else if (len <= LEN_W'(511))   return 3'd3;
    else if (len <= LEN_W'(1023))  return 3'd4;
    else if (len <= LEN_W'(1518))  return 3'd5;
    else if (len <= mtu)           return 3'd6;
    else                           return 3'(BIN_CNT);
  endfunction
endpackage

// File: rtl/macStatCtrl.sv
module macStatCtrl
  import macStatPkg::*;
(
  input  logic [LEN_W-1:0] mtu,
  input  logic             rxValid,
  input  logic [LEN_W-1:0] rxLen,
  input  logic             rxFcsOk,
  input  logic             rxBcast,
  input  logic             rxMcast,
  input  logic             rxPause,
  input  logic             rxCtrl,
  input  logic             rxLenErr,
  input  logic             rxFifoOvf,
  input  logic             rxRingOvf,
  input  logic             rxAddrDrop,
  input  logic             txValid,
  input  logic [LEN_W-1:0] txLen,
  input  logic             txBcast,
  input  logic             txMcast,
  input  logic             txPause,
  input  logic             txCtrl,
  input  logic [3:0]       txColls,
  input  logic             txLateCol,
  input  logic             txAbort,
  input  logic             txDefer,
  input  logic             txExcDefer,
  output strobe_t          strb
);
  logic rxShort, rxOver, rxDrop, rxGood;
  logic txShort, txOver, txGood;
  logic [2:0] rxBin, txBin;
  logic [NUM_CNT-1:0] hit;

  always_comb begin
    rxShort = rxLen < MIN_LEN;
    rxOver  = rxLen > mtu;
    rxDrop  = rxFifoOvf | rxRingOvf | rxAddrDrop;
    rxGood  = rxValid & rxFcsOk & ~rxLenErr & ~rxDrop & ~rxShort & ~rxOver;
    rxBin   = lenBin(rxLen, mtu);
    txShort = txLen < MIN_LEN;
    txOver  = txLen > mtu;
    txGood  = txValid & ~txLateCol & ~txAbort & ~txShort & ~txOver;
    txBin   = lenBin(txLen, mtu);
  end

  always_comb begin
    hit = '0;
    // receive side
    hit[RX_GOOD]     = rxGood;
    hit[RX_BCAST]    = rxGood & rxBcast;
    hit[RX_MCAST]    = rxGood & rxMcast;
    hit[RX_PAUSE]    = rxGood & rxPause;
    hit[RX_CTRL]     = rxGood & rxCtrl & ~rxPause;
    hit[RX_FCSERR]   = rxValid & ~rxFcsOk & ~rxShort;
    hit[RX_LENERR]   = rxValid & rxLenErr;
    hit[RX_RUNT]     = rxValid & rxShort & rxFcsOk;
    hit[RX_FRAG]     = rxValid & rxShort & ~rxFcsOk;
    hit[RX_OVERSIZE] = rxValid & rxOver;
    hit[RX_FIFODROP] = rxValid & rxFifoOvf;
    hit[RX_RINGDROP] = rxValid & rxRingOvf;
    hit[RX_ADDRDROP] = rxValid & rxAddrDrop;
    hit[RX_BYTES]    = rxGood;
    hit[RX_BCBYTES]  = rxGood & rxBcast;
    hit[RX_MCBYTES]  = rxGood & rxMcast;
    // transmit side
    hit[TX_GOOD]     = txGood;
    hit[TX_BCAST]    = txGood & txBcast;
    hit[TX_MCAST]    = txGood & txMcast;
    hit[TX_PAUSE]    = txGood & txPause;
    hit[TX_CTRL]     = txGood & txCtrl & ~txPause;
    hit[TX_DEFER]    = txValid & txDefer;
    hit[TX_EXCDEFER] = txValid & txExcDefer;
    hit[TX_ONECOL]   = txGood & (txColls == 4'd1);
    hit[TX_MULTICOL] = txGood & (txColls >= 4'd2);
    hit[TX_LATECOL]  = txValid & txLateCol;
    hit[TX_ABORT]    = txValid & txAbort;
    hit[TX_TRUNC]    = txValid & txOver;
    hit[TX_BYTES]    = txGood;
    hit[TX_BCBYTES]  = txGood & txBcast;
    hit[TX_MCBYTES]  = txGood & txMcast;
    for (int b = 0; b < BIN_CNT; b++) begin
      hit[RX_BIN0 + b] = rxGood & (rxBin == 3'(b));
      hit[TX_BIN0 + b] = txGood & (txBin == 3'(b));
    end
  end

  assign strb.hit     = hit;
  assign strb.rxBytes = rxLen - FCS_LEN;
  assign strb.txBytes = txLen - FCS_LEN;
  assign strb.update  = rxValid | txValid;
endmodule

// File: rtl/macStatDatapath.sv
module macStatDatapath
  import macStatPkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bankClr,
  input  logic             flagClr,
  input  strobe_t          strb,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [CNT_W-1:0] rdData,
  output logic             updFlag
);
  localparam int SUM_W = ((CNT_W > LEN_W) ? CNT_W : LEN_W) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt [NUM_CNT];

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    localparam bit IS_RXB = isRxByte(i);
    localparam bit IS_TXB = isTxByte(i);
    logic [LEN_W-1:0] amt;
    logic [SUM_W-1:0] sum;

    if (IS_RXB) begin : g_rxb
      assign amt = strb.rxBytes;
    end else if (IS_TXB) begin : g_txb
      assign amt = strb.txBytes;
    end else begin : g_evt
      assign amt = LEN_W'(1);
    end

    assign sum = {{(SUM_W-CNT_W){1'b0}}, cnt[i]} + {{(SUM_W-LEN_W){1'b0}}, amt};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  cnt[i] <= '0;
      else if (bankClr)           cnt[i] <= '0;
      else if (strb.hit[i]) begin
        if (|sum[SUM_W-1:CNT_W])  cnt[i] <= CNT_MAX;
        else                      cnt[i] <= sum[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          rdData <= '0;
    else if (rdIdx < IDX_W'(NUM_CNT))   rdData <= cnt[rdIdx];
    else                                rdData <= '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             updFlag <= 1'b0;
    else if (bankClr)      updFlag <= 1'b0;
    else if (strb.update)  updFlag <= 1'b1;
    else if (flagClr)      updFlag <= 1'b0;
  end
endmodule

// File: rtl/macStatBank.sv
module macStatBank
  import macStatPkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bankClr,
  input  logic [15:0]      mtu,
  input  logic             rxValid,
  input  logic [15:0]      rxLen,
  input  logic             rxFcsOk,
  input  logic             rxBcast,
  input  logic             rxMcast,
  input  logic             rxPause,
  input  logic             rxCtrl,
  input  logic             rxLenErr,
  input  logic             rxFifoOvf,
  input  logic             rxRingOvf,
  input  logic             rxAddrDrop,
  input  logic             txValid,
  input  logic [15:0]      txLen,
  input  logic             txBcast,
  input  logic             txMcast,
  input  logic             txPause,
  input  logic             txCtrl,
  input  logic [3:0]       txColls,
  input  logic             txLateCol,
  input  logic             txAbort,
  input  logic             txDefer,
  input  logic             txExcDefer,
  input  logic [5:0]       rdIdx,
  output logic [CNT_W-1:0] rdData,
  input  logic             flagClr,
  output logic             updFlag
);
  strobe_t strb;

  macStatCtrl u_ctrl (
    .mtu(mtu), .rxValid(rxValid), .rxLen(rxLen), .rxFcsOk(rxFcsOk),
    .rxBcast(rxBcast), .rxMcast(rxMcast), .rxPause(rxPause), .rxCtrl(rxCtrl),
    .rxLenErr(rxLenErr), .rxFifoOvf(rxFifoOvf), .rxRingOvf(rxRingOvf),
    .rxAddrDrop(rxAddrDrop), .txValid(txValid), .txLen(txLen),
    .txBcast(txBcast), .txMcast(txMcast), .txPause(txPause), .txCtrl(txCtrl),
    .txColls(txColls), .txLateCol(txLateCol), .txAbort(txAbort),
    .txDefer(txDefer), .txExcDefer(txExcDefer), .strb(strb)
  );

  macStatDatapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .bankClr(bankClr), .flagClr(flagClr),
    .strb(strb), .rdIdx(rdIdx), .rdData(rdData), .updFlag(updFlag)
  );
endmodule

// File: rtl/macStatChk.sv
module macStatChk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             bankClr,
  input logic             rxValid,
  input logic             txValid,
  input logic [5:0]       rdIdx,
  input logic [CNT_W-1:0] rdData,
  input logic             flagClr,
  input logic             updFlag
);
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid || txValid) && !bankClr |=> updFlag); // R12
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    updFlag && !flagClr && !bankClr |=> updFlag); // R12
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    flagClr && !rxValid && !txValid |=> !updFlag); // R12
  AST_CLR_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    bankClr |=> !updFlag); // R11
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    bankClr |=> ##1 (rdData == '0)); // R11
  AST_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdIdx >= 6'd45 |=> rdData == '0); // R1
endmodule

bind macStatBank macStatChk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .bankClr(bankClr), .rxValid(rxValid),
  .txValid(txValid), .rdIdx(rdIdx), .rdData(rdData), .flagClr(flagClr),
  .updFlag(updFlag)
);

// File: tb/test_macStatBank.sv
module test_macStatBank;
  localparam int CW = 12;
  localparam logic [CW-1:0] SAT = '1;
  localparam int NV = 23;
  // vector: len[50:35] flags[34:26] idx[25:20] exp[19:4] req[3:0]
  // flags: 0 fcsOk 1 bcast 2 mcast 3 pause 4 ctrl 5 lenErr 6 fifo 7 ring 8 addr
  localparam logic [50:0] VECS [NV] = '{
    {16'd100,  9'h001, 6'd0,  16'd1,   4'd2},  // R2 good
    {16'd100,  9'h001, 6'd20, 16'd96,  4'd3},  // R3 bytes
    {16'd64,   9'h003, 6'd9,  16'd1,   4'd5},  // R5 bin0
    {16'd64,   9'h003, 6'd21, 16'd60,  4'd3},  // R3 bcast bytes
    {16'd65,   9'h001, 6'd10, 16'd1,   4'd5},  // R5 bin1 low
    {16'd127,  9'h001, 6'd10, 16'd1,   4'd5},  // R5 bin1 high
    {16'd128,  9'h001, 6'd11, 16'd1,   4'd5},  // R5 bin2
    {16'd1518, 9'h001, 6'd14, 16'd1,   4'd5},  // R5 bin5 top
    {16'd1519, 9'h001, 6'd16, 16'd1,   4'd6},  // R6 oversize
    {16'd1519, 9'h001, 6'd0,  16'd0,   4'd6},  // R6 not good
    {16'd60,   9'h001, 6'd7,  16'd1,   4'd4},  // R4 runt
    {16'd60,   9'h000, 6'd8,  16'd1,   4'd4},  // R4 fragment
    {16'd60,   9'h000, 6'd5,  16'd0,   4'd4},  // R4 short not fcs err
    {16'd200,  9'h000, 6'd5,  16'd1,   4'd4},  // R4 fcs err
    {16'd200,  9'h019, 6'd3,  16'd1,   4'd7},  // R7 pause
    {16'd200,  9'h019, 6'd4,  16'd0,   4'd7},  // R7 pause not control
    {16'd200,  9'h011, 6'd4,  16'd1,   4'd7},  // R7 control
    {16'd200,  9'h005, 6'd22, 16'd196, 4'd3},  // R3 mcast bytes
    {16'd200,  9'h041, 6'd17, 16'd1,   4'd9},  // R9 fifo
    {16'd200,  9'h041, 6'd0,  16'd0,   4'd2},  // R2 dropped not good
    {16'd200,  9'h081, 6'd18, 16'd1,   4'd9},  // R9 ring
    {16'd200,  9'h101, 6'd19, 16'd1,   4'd9},  // R9 addr
    {16'd200,  9'h021, 6'd6,  16'd1,   4'd9}   // R9 length error
  };

  logic clk = 1'b0, rstN = 1'b0, bankClr = 1'b0, flagClr = 1'b0;
  logic [15:0] mtu = 16'd1518;
  logic rxValid = 0, rxFcsOk = 0, rxBcast = 0, rxMcast = 0, rxPause = 0, rxCtrl = 0;
  logic rxLenErr = 0, rxFifoOvf = 0, rxRingOvf = 0, rxAddrDrop = 0;
  logic [15:0] rxLen = '0, txLen = '0;
  logic txValid = 0, txBcast = 0, txMcast = 0, txPause = 0, txCtrl = 0;
  logic txLateCol = 0, txAbort = 0, txDefer = 0, txExcDefer = 0;
  logic [3:0] txColls = '0;
  logic [5:0] rdIdx = '0;
  logic [CW-1:0] rdData;
  logic updFlag;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  macStatBank #(.CNT_W(CW)) i_macStatBank (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setRx(input logic [15:0] len, input logic [8:0] f);
    rxLen = len; rxFcsOk = f[0]; rxBcast = f[1]; rxMcast = f[2]; rxPause = f[3];
    rxCtrl = f[4]; rxLenErr = f[5]; rxFifoOvf = f[6]; rxRingOvf = f[7]; rxAddrDrop = f[8];
  endtask

  task automatic setTx(input logic [15:0] len, input logic bc, input logic mc,
                       input logic [3:0] colls, input logic [3:0] f);
    txLen = len; txBcast = bc; txMcast = mc; txColls = colls;
    txLateCol = f[0]; txAbort = f[1]; txDefer = f[2]; txExcDefer = f[3];
  endtask

  task automatic cycle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic clearBank();
    bankClr = 1'b1; cycle(); bankClr = 1'b0;
  endtask

  task automatic pulseRx();
    rxValid = 1'b1; cycle(); rxValid = 1'b0;
  endtask

  task automatic pulseTx();
    txValid = 1'b1; cycle(); txValid = 1'b0;
  endtask

  task automatic readCnt(input int idx, output int val);
    rdIdx = 6'(idx); cycle(); val = int'(rdData);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 flag after reset", int'(updFlag), 0);
    readCnt(0, v); check("R11 counter after reset", v, 0);

    // table walk: clear, one receive report, read one counter
    for (int k = 0; k < NV; k++) begin
      clearBank();
      setRx(VECS[k][50:35], VECS[k][34:26]);
      pulseRx();
      readCnt(int'(VECS[k][25:20]), v);
      check($sformatf("R%0d vector %0d", VECS[k][3:0], k), v, int'(VECS[k][19:4]));
    end

    // R5 bin 6 with a raised mtu
    clearBank(); mtu = 16'd2000; setRx(16'd1600, 9'h001); pulseRx();
    readCnt(15, v); check("R5 rx bin6", v, 1);
    mtu = 16'd1518;

    // R13 concurrent rx and tx, plus tx bins and collisions (R8)
    clearBank();
    setRx(16'd100, 9'h001); setTx(16'd300, 1'b0, 1'b0, 4'd1, 4'h0);
    rxValid = 1'b1; txValid = 1'b1; cycle(); rxValid = 1'b0; txValid = 1'b0;
    readCnt(0, v);  check("R13 rx good", v, 1);
    readCnt(23, v); check("R13 tx good", v, 1);
    readCnt(30, v); check("R8 one collision", v, 1);
    readCnt(38, v); check("R5 tx bin3", v, 1);
    readCnt(42, v); check("R3 tx bytes", v, 296);

    clearBank(); setTx(16'd500, 1'b1, 1'b0, 4'd3, 4'h0); pulseTx();
    readCnt(31, v); check("R8 several collisions", v, 1);
    readCnt(30, v); check("R8 not one collision", v, 0);
    readCnt(43, v); check("R3 tx bcast bytes", v, 496);

    clearBank(); setTx(16'd500, 1'b0, 1'b0, 4'd0, 4'h1); pulseTx();
    readCnt(32, v); check("R8 late collision", v, 1);
    readCnt(23, v); check("R2 late collision not good", v, 0);
    clearBank(); setTx(16'd500, 1'b0, 1'b0, 4'd0, 4'h2); pulseTx();
    readCnt(33, v); check("R8 abort", v, 1);
    clearBank(); setTx(16'd500, 1'b0, 1'b0, 4'd0, 4'hC); pulseTx();
    readCnt(28, v); check("R8 deferred", v, 1);
    readCnt(29, v); check("R8 excess deferred", v, 1);
    clearBank(); setTx(16'd1600, 1'b0, 1'b0, 4'd0, 4'h0); pulseTx();
    readCnt(34, v); check("R6 tx truncated", v, 1);
    readCnt(23, v); check("R6 truncated not good", v, 0);

    // R7 tx pause vs control
    clearBank(); setTx(16'd64, 1'b0, 1'b0, 4'd0, 4'h0); txPause = 1'b1; txCtrl = 1'b1; pulseTx();
    readCnt(26, v); check("R7 tx pause", v, 1);
    readCnt(27, v); check("R7 tx pause not control", v, 0);
    txPause = 1'b0; txCtrl = 1'b0;

    // R1 out-of-range index
    readCnt(50, v); check("R1 out of range read", v, 0);

    // R12 update flag
    clearBank();
    check("R12 flag low after clear", int'(updFlag), 0);
    setRx(16'd100, 9'h001); pulseRx();
    check("R12 flag set", int'(updFlag), 1);
    cycle(); cycle();
    check("R12 flag held", int'(updFlag), 1);
    flagClr = 1'b1; cycle(); flagClr = 1'b0;
    check("R12 flag cleared", int'(updFlag), 0);
    flagClr = 1'b1; rxValid = 1'b1; cycle(); flagClr = 1'b0; rxValid = 1'b0;
    check("R12 set wins over clear", int'(updFlag), 1);
    clearBank();
    check("R11 clear drops flag", int'(updFlag), 0);

    // R10 saturation
    clearBank(); setRx(16'd1518, 9'h001);
    rxValid = 1'b1; repeat (4100) cycle(); rxValid = 1'b0;
    readCnt(0, v);  check("R10 event saturates", v, int'(SAT));
    readCnt(20, v); check("R10 bytes saturate", v, int'(SAT));
    readCnt(1, v);  check("R10 neighbour untouched", v, 0);

    // R11 bank clear zeroes
    clearBank(); readCnt(0, v); check("R11 clear zeroes", v, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule